// File: doc/BRIEF.md
# Serpentine Column Shift Sequencer

This block sequences constant-time insert and delete shifts in a word memory built from short columns. The columns are folded end to end in a serpentine pattern, so each column's last word touches the first word of the next column, and neighbouring columns run their addresses in opposite physical directions. A command carries an insert address, a delete address and a new data word. The direction of the shift follows from the two addresses. If the insert address is lower than the delete address, the words between them move toward higher addresses. If it is higher, they move toward lower addresses.

The controller splits each command into a short schedule of array cycles. The column that holds the delete address shifts first, as a partial shift. All columns strictly between the two end columns then shift together, and each of them takes one word across its column end. The column that holds the insert address shifts last, as a partial shift. A normal write of the new word at the insert address ends the command. Each array cycle lasts four clocks, one for each cell step: enter dynamic hold, transfer, close the forward loop, restore static storage. The behavioural column array stores each word at its physical row and exposes a combinational read port by logical address.

The FSM states are SQ_IDLE, SQ_DEL, SQ_MID, SQ_INS, SQ_ONE, SQ_WRITE and SQ_DONE. The transitions are:
- SQ_IDLE to SQ_WRITE when the two addresses are equal.
- SQ_IDLE to SQ_ONE when both addresses lie in the same column.
- SQ_IDLE to SQ_DEL otherwise.
- SQ_DEL to SQ_MID, or to SQ_INS when the two end columns are adjacent.
- SQ_MID to SQ_INS.
- SQ_INS to SQ_WRITE.
- SQ_ONE to SQ_WRITE.
- SQ_WRITE to SQ_DONE.
- SQ_DONE to SQ_IDLE.

Each working state holds for one four-clock array cycle. SQ_DONE lasts one clock.

Top module: `serpentine_shift_seq`

## Requirements
- R1: After reset, the word at each logical address a holds the value a. Reset also leaves cmd_ready at 1, done at 0, col_en at 0 and cell_step at 0.
- R2: Logical address a lies in column a/16 at position a%16. Position p is at row p in even columns and at row 15-p in odd columns. rd_data returns the word at logical address rd_addr in the same cycle.
- R3: When ins < del, the old words at ins..del-1 end up at ins+1..del, and the old word at del is lost. The new word is stored at ins, and every other address is unchanged. This holds for commands that cross column ends.
- R4: When ins > del, the old words at del+1..ins end up at del..ins-1, and the old word at del is lost. The new word is stored at ins, and every other address is unchanged.
- R5: When ins == del, the command writes the new word at that address and moves nothing else.
- R6: col_en follows a fixed schedule of array cycles. First comes bit del/16 alone. Next come the bits of the columns strictly between the two end columns; this cycle is skipped when there are none. Next comes bit ins/16 alone. Last comes a write cycle with col_en = 0. A command inside one column gives bit ins/16 and then the write cycle. cell_step counts 0,1,2,3 (hold, transfer, close, restore) within every array cycle.
- R7: Counted from the clock edge that accepts a command, done rises after a fixed number of clocks. It is 16 when the end columns are two or more apart, 12 when they are adjacent, 8 when both addresses share a column and 4 when the addresses are equal.
- R8: For every column c whose col_en bit is 1, col_pdir[c] equals (ins < del) XOR (c odd). The value 1 means data moves toward higher rows. col_pdir[c] is 0 for every column whose col_en bit is 0.
- R9: cmd_ready stays 0 from the accepting edge until the sequence ends. cmd_valid during that time has no effect on memory contents, and no extra done follows.
- R10: done is high for exactly one clock after the write cycle. cmd_ready returns to 1 in the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request, taken when cmd_ready is 1 |
| cmd_ins | input | 7 | Insert address, where the new word is written |
| cmd_del | input | 7 | Delete address, whose word is overwritten by the shift |
| cmd_data | input | 8 | New word to store at the insert address |
| cmd_ready | output | 1 | High while idle and able to take a command |
| done | output | 1 | One-clock pulse when a command finishes |
| rd_addr | input | 7 | Logical read address |
| rd_data | output | 8 | Word at rd_addr |
| col_en | output | 8 | Per-column shift enables for the current array cycle |
| col_pdir | output | 8 | Physical shift direction of each enabled column |
| cell_step | output | 2 | Cell step within the array cycle (0 hold, 1 transfer, 2 close, 3 restore) |

## Verification
The assertions check every cycle that:
- a command offered while busy leaves the latched addresses and data unchanged;
- done lasts a single clock and follows the write cycle;
- exactly one column is enabled in each partial-shift cycle;
- no transfer coincides with the final write.

Only the bench's scenarios can show that the moved words land in the right places across column ends in both directions. The same holds for the schedule and budget of each distance class, the alternating physical directions, and the boundary cases. Those boundary cases are an insert word at the end of its column, a span over the whole memory, and commands issued while busy.

// File: rtl/serp_pkg.sv
`timescale 1ns/1ps
package serp_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_DEL,
        SQ_MID,
        SQ_INS,
        SQ_ONE,
        SQ_WRITE,
        SQ_DONE
    } sq_state_e;

    typedef enum logic [1:0] {
        ST_HOLD,
        ST_XFER,
        ST_CLOSE,
        ST_RESTORE
    } cell_step_e;

endpackage

// File: rtl/serp_span_plan.sv
`timescale 1ns/1ps
// Address decode for one command: end columns, positions, direction,
// distance class and the set of columns lying strictly between the ends.
module serp_span_plan #(
    parameter int NCOL   = 8,
    parameter int CDEPTH = 16,
    localparam int AW    = $clog2(NCOL * CDEPTH),
    localparam int PW    = $clog2(CDEPTH),
    localparam int CW    = $clog2(NCOL)
) (
    input  logic [AW-1:0]   ins_addr,
    input  logic [AW-1:0]   del_addr,
    output logic [CW-1:0]   ins_col,
    output logic [CW-1:0]   del_col,
    output logic [PW-1:0]   ins_pos,
    output logic [PW-1:0]   del_pos,
    output logic            up,
    output logic            same_col,
    output logic            same_addr,
    output logic            adjacent,
    output logic [NCOL-1:0] mid_mask
);
    logic [CW-1:0] lo_col;
    logic [CW-1:0] hi_col;

    assign ins_col   = ins_addr[AW-1:PW];
    assign del_col   = del_addr[AW-1:PW];
    assign ins_pos   = ins_addr[PW-1:0];
    assign del_pos   = del_addr[PW-1:0];
    assign up        = ins_addr < del_addr;
    assign same_col  = ins_col == del_col;
    assign same_addr = ins_addr == del_addr;
    assign lo_col    = up ? ins_col : del_col;
    assign hi_col    = up ? del_col : ins_col;
    assign adjacent  = (hi_col - lo_col) == CW'(1);

    for (genvar c = 0; c < NCOL; c++) begin : g_mid
        assign mid_mask[c] = (CW'(c) > lo_col) && (CW'(c) < hi_col);
    end
endmodule

// File: rtl/serp_seq_ctrl.sv
`timescale 1ns/1ps
// Phase sequencer: latches a command, walks the delete / middle / insert
// shift cycles and the final write, each array cycle being four cell steps.
module serp_seq_ctrl
    import serp_pkg::*;
#(
    parameter int NCOL   = 8,
    parameter int CDEPTH = 16,
    parameter int DW     = 8,
    localparam int AW    = $clog2(NCOL * CDEPTH),
    localparam int PW    = $clog2(CDEPTH),
    localparam int CW    = $clog2(NCOL)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [AW-1:0]   cmd_ins,
    input  logic [AW-1:0]   cmd_del,
    input  logic [DW-1:0]   cmd_data,
    output logic            cmd_ready,
    output logic            done,
    output logic [AW-1:0]   plan_ins,
    output logic [AW-1:0]   plan_del,
    input  logic [CW-1:0]   ins_col,
    input  logic [CW-1:0]   del_col,
    input  logic [PW-1:0]   ins_pos,
    input  logic [PW-1:0]   del_pos,
    input  logic            up,
    input  logic            same_col,
    input  logic            same_addr,
    input  logic            adjacent,
    input  logic [NCOL-1:0] mid_mask,
    output logic [NCOL-1:0] col_en,
    output logic [NCOL-1:0] col_pdir,
    output logic [PW:0]     rng_lo,
    output logic [PW:0]     rng_hi,
    output logic            shift_go,
    output logic            wr_en,
    output logic [AW-1:0]   wr_addr,
    output logic [DW-1:0]   wr_data,
    output logic [1:0]      step_out
);
    localparam logic [PW:0] FULL_R = (PW+1)'(CDEPTH);
    localparam logic [PW:0] ONE_R  = (PW+1)'(1);

    sq_state_e  state, state_nx;
    cell_step_e step, step_nx;
    logic [AW-1:0] ins_q, del_q;
    logic [DW-1:0] data_q;
    logic          working;
    logic          accept;
    logic [PW:0]   ipos_w, dpos_w;

    assign accept   = cmd_valid && (state == SQ_IDLE);
    assign plan_ins = (state == SQ_IDLE) ? cmd_ins : ins_q;
    assign plan_del = (state == SQ_IDLE) ? cmd_del : del_q;
    assign working  = state inside {SQ_DEL, SQ_MID, SQ_INS, SQ_ONE, SQ_WRITE};
    assign step_nx  = working ? cell_step_e'(step + 2'd1) : ST_HOLD;
    assign ipos_w   = {1'b0, ins_pos};
    assign dpos_w   = {1'b0, del_pos};
    assign wr_addr  = ins_q;
    assign wr_data  = data_q;
    assign step_out = step;

    // state register and command latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            step   <= ST_HOLD;
            ins_q  <= '0;
            del_q  <= '0;
            data_q <= '0;
        end else begin
            state <= state_nx;
            step  <= step_nx;
            if (accept) begin
                ins_q  <= cmd_ins;
                del_q  <= cmd_del;
                data_q <= cmd_data;
            end
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_IDLE: begin
                if (cmd_valid) begin
                    if (same_addr)     state_nx = SQ_WRITE;
                    else if (same_col) state_nx = SQ_ONE;
                    else               state_nx = SQ_DEL;
                end
            end
            SQ_DEL:   if (step == ST_RESTORE) state_nx = adjacent ? SQ_INS : SQ_MID;
            SQ_MID:   if (step == ST_RESTORE) state_nx = SQ_INS;
            SQ_INS:   if (step == ST_RESTORE) state_nx = SQ_WRITE;
            SQ_ONE:   if (step == ST_RESTORE) state_nx = SQ_WRITE;
            SQ_WRITE: if (step == ST_RESTORE) state_nx = SQ_DONE;
            SQ_DONE:  state_nx = SQ_IDLE;
            default:  state_nx = SQ_IDLE;
        endcase
    end

    // outputs; ranges are half-open [rng_lo, rng_hi) of receiving positions
    always_comb begin
        col_en    = '0;
        rng_lo    = '0;
        rng_hi    = '0;
        wr_en     = 1'b0;
        done      = 1'b0;
        cmd_ready = 1'b0;
        unique case (state)
            SQ_IDLE: cmd_ready = 1'b1;
            SQ_DEL: begin
                col_en[del_col] = 1'b1;
                rng_lo = up ? '0 : dpos_w;
                rng_hi = up ? (dpos_w + ONE_R) : FULL_R;
            end
            SQ_MID: begin
                col_en = mid_mask;
                rng_lo = '0;
                rng_hi = FULL_R;
            end
            SQ_INS: begin
                col_en[ins_col] = 1'b1;
                rng_lo = up ? (ipos_w + ONE_R) : '0;
                rng_hi = up ? FULL_R : ipos_w;
            end
            SQ_ONE: begin
                col_en[ins_col] = 1'b1;
                rng_lo = up ? (ipos_w + ONE_R) : dpos_w;
                rng_hi = up ? (dpos_w + ONE_R) : ipos_w;
            end
            SQ_WRITE: wr_en = (step == ST_XFER);
            SQ_DONE:  done  = 1'b1;
            default: ;
        endcase
        shift_go = (col_en != '0) && (step == ST_XFER);
    end

    for (genvar c = 0; c < NCOL; c++) begin : g_pdir
        assign col_pdir[c] = col_en[c] & (up ^ ((c % 2) == 1));
    end

    assert_refuse_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> ($stable(ins_q) && $stable(del_q) && $stable(data_q)));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(state) == SQ_WRITE));

    assert_partial_one_col_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {SQ_DEL, SQ_INS, SQ_ONE}) |-> ($countones(col_en) == 1));
endmodule

// File: rtl/serp_col_array.sv
`timescale 1ns/1ps
// Behavioural serpentine column array. Words sit at physical rows; odd
// columns are mirrored. Column ends are joined so a word can cross into
// the neighbouring column during a transfer step.
module serp_col_array #(
    parameter int NCOL   = 8,
    parameter int CDEPTH = 16,
    parameter int DW     = 8,
    localparam int AW    = $clog2(NCOL * CDEPTH),
    localparam int PW    = $clog2(CDEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCOL-1:0] col_en,
    input  logic [PW:0]     rng_lo,
    input  logic [PW:0]     rng_hi,
    input  logic            up,
    input  logic            shift_go,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data
);
    logic [DW-1:0] mem [NCOL][CDEPTH];
    logic [DW-1:0] src [NCOL][CDEPTH];

    function automatic int row_of(input int col, input int pos);
        return ((col % 2) == 1) ? (CDEPTH - 1 - pos) : pos;
    endfunction

    // candidate value each cell would take on a transfer step
    always_comb begin
        for (int c = 0; c < NCOL; c++) begin
            for (int r = 0; r < CDEPTH; r++) begin
                int p;
                int cl;
                int cr;
                p  = row_of(c, r);
                cl = (c > 0) ? c - 1 : 0;
                cr = (c < NCOL - 1) ? c + 1 : NCOL - 1;
                if (up) begin
                    if (p == 0) src[c][r] = mem[cl][row_of(cl, CDEPTH - 1)];
                    else        src[c][r] = mem[c][row_of(c, p - 1)];
                end else begin
                    if (p == CDEPTH - 1) src[c][r] = mem[cr][row_of(cr, 0)];
                    else                 src[c][r] = mem[c][row_of(c, p + 1)];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCOL; c++)
                for (int r = 0; r < CDEPTH; r++)
                    mem[c][r] <= DW'(c * CDEPTH + row_of(c, r));
        end else if (shift_go) begin
            for (int c = 0; c < NCOL; c++) begin
                for (int r = 0; r < CDEPTH; r++) begin
                    int p;
                    p = row_of(c, r);
                    if (col_en[c] && (p >= int'(rng_lo)) && (p < int'(rng_hi)))
                        mem[c][r] <= src[c][r];
                end
            end
        end else if (wr_en) begin
            mem[int'(wr_addr[AW-1:PW])]
               [row_of(int'(wr_addr[AW-1:PW]), int'(wr_addr[PW-1:0]))] <= wr_data;
        end
    end

    always_comb begin
        rd_data = mem[int'(rd_addr[AW-1:PW])]
                     [row_of(int'(rd_addr[AW-1:PW]), int'(rd_addr[PW-1:0]))];
    end

    assert_no_shift_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !shift_go);
endmodule

// File: rtl/serpentine_shift_seq.sv
`timescale 1ns/1ps
module serpentine_shift_seq #(
    parameter int NCOL   = 8,
    parameter int CDEPTH = 16,
    parameter int DW     = 8,
    localparam int AW    = $clog2(NCOL * CDEPTH),
    localparam int PW    = $clog2(CDEPTH),
    localparam int CW    = $clog2(NCOL)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [AW-1:0]   cmd_ins,
    input  logic [AW-1:0]   cmd_del,
    input  logic [DW-1:0]   cmd_data,
    output logic            cmd_ready,
    output logic            done,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    output logic [NCOL-1:0] col_en,
    output logic [NCOL-1:0] col_pdir,
    output logic [1:0]      cell_step
);
    logic [AW-1:0]   plan_ins, plan_del;
    logic [CW-1:0]   ins_col, del_col;
    logic [PW-1:0]   ins_pos, del_pos;
    logic            up, same_col, same_addr, adjacent;
    logic [NCOL-1:0] mid_mask;
    logic [PW:0]     rng_lo, rng_hi;
    logic            shift_go, wr_en;
    logic [AW-1:0]   wr_addr;
    logic [DW-1:0]   wr_data;

    serp_span_plan #(.NCOL(NCOL), .CDEPTH(CDEPTH)) u_plan (
        .ins_addr (plan_ins),
        .del_addr (plan_del),
        .ins_col  (ins_col),
        .del_col  (del_col),
        .ins_pos  (ins_pos),
        .del_pos  (del_pos),
        .up       (up),
        .same_col (same_col),
        .same_addr(same_addr),
        .adjacent (adjacent),
        .mid_mask (mid_mask)
    );

    serp_seq_ctrl #(.NCOL(NCOL), .CDEPTH(CDEPTH), .DW(DW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_ins  (cmd_ins),
        .cmd_del  (cmd_del),
        .cmd_data (cmd_data),
        .cmd_ready(cmd_ready),
        .done     (done),
        .plan_ins (plan_ins),
        .plan_del (plan_del),
        .ins_col  (ins_col),
        .del_col  (del_col),
        .ins_pos  (ins_pos),
        .del_pos  (del_pos),
        .up       (up),
        .same_col (same_col),
        .same_addr(same_addr),
        .adjacent (adjacent),
        .mid_mask (mid_mask),
        .col_en   (col_en),
        .col_pdir (col_pdir),
        .rng_lo   (rng_lo),
        .rng_hi   (rng_hi),
        .shift_go (shift_go),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .step_out (cell_step)
    );

    serp_col_array #(.NCOL(NCOL), .CDEPTH(CDEPTH), .DW(DW)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .col_en  (col_en),
        .rng_lo  (rng_lo),
        .rng_hi  (rng_hi),
        .up      (up),
        .shift_go(shift_go),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );
endmodule

// File: tb/serpentine_shift_seq_test.sv
`timescale 1ns/1ps
module serpentine_shift_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [6:0] cmd_ins = '0;
    logic [6:0] cmd_del = '0;
    logic [7:0] cmd_data = '0;
    logic [6:0] rd_addr = '0;
    logic       cmd_ready, done;
    logic [7:0] rd_data;
    logic [7:0] col_en, col_pdir;
    logic [1:0] cell_step;

    int checks = 0;
    int failures = 0;
    logic [7:0] ref_mem [128];

    serpentine_shift_seq uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ins(cmd_ins),
        .cmd_del(cmd_del), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
        .done(done), .rd_addr(rd_addr), .rd_data(rd_data), .col_en(col_en),
        .col_pdir(col_pdir), .cell_step(cell_step)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_mem(input string req);
        int bad = 0;
        for (int a = 0; a < 128; a++) begin
            rd_addr = 7'(a);
            #0.1;
            if (rd_data !== ref_mem[a]) bad++;
        end
        chk(req, bad, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 128; a++) ref_mem[a] = 8'(a);
        chk("R1 cmd_ready after reset", int'(cmd_ready), 1);
        chk("R1 done/col_en/cell_step after reset", int'({done, col_en, cell_step}), 0);
        chk_mem("R1 R2 reset contents by logical address");
    endtask

    task automatic run_op(input int ins, input int del, input logic [7:0] d,
                          input bit noise, input string req);
        int ic = ins / 16;
        int dc = del / 16;
        bit up = ins < del;
        int seq [4];
        int ncyc, expk, sched_bad, pdir_bad, done_k, lo, hi, mid;
        if (ins == del) begin
            seq[0] = 0; ncyc = 1;
        end else if (ic == dc) begin
            seq[0] = 1 << ic; seq[1] = 0; ncyc = 2;
        end else begin
            lo = (ic < dc) ? ic : dc;
            hi = (ic < dc) ? dc : ic;
            mid = 0;
            for (int c = lo + 1; c < hi; c++) mid |= (1 << c);
            seq[0] = 1 << dc;
            if (hi - lo > 1) begin
                seq[1] = mid; seq[2] = 1 << ic; seq[3] = 0; ncyc = 4;
            end else begin
                seq[1] = 1 << ic; seq[2] = 0; ncyc = 3;
            end
        end
        expk = ncyc * 4;
        @(negedge clk);
        chk({req, " R9 ready before command"}, int'(cmd_ready), 1);
        cmd_valid = 1'b1; cmd_ins = 7'(ins); cmd_del = 7'(del); cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        sched_bad = 0; pdir_bad = 0; done_k = -1;
        for (int k = 0; k <= expk + 1; k++) begin
            if (noise && k >= 2 && k <= 6) begin
                cmd_valid = 1'b1; cmd_ins = 7'd3; cmd_del = 7'd90; cmd_data = 8'hEE;
            end else begin
                cmd_valid = 1'b0;
            end
            if (k < expk) begin
                if (int'(col_en) != seq[k / 4] || int'(cell_step) != (k % 4) || done || cmd_ready)
                    sched_bad++;
                for (int c = 0; c < 8; c++) begin
                    if (col_pdir[c] !== (col_en[c] & (up ^ c[0]))) pdir_bad++;
                end
            end
            if (done && done_k < 0) done_k = k;
            if (k == expk) chk({req, " R10 done high"}, int'(done), 1);
            if (k == expk + 1) begin
                chk({req, " R10 done one clock"}, int'(done), 0);
                chk({req, " R10 ready returns"}, int'(cmd_ready), 1);
            end
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        chk({req, " R7 clocks to done"}, done_k, expk);
        chk({req, " R6 schedule mismatches"}, sched_bad, 0);
        chk({req, " R8 direction mismatches"}, pdir_bad, 0);
        if (ins < del) for (int a = del; a > ins; a--) ref_mem[a] = ref_mem[a - 1];
        else if (ins > del) for (int a = del; a < ins; a++) ref_mem[a] = ref_mem[a + 1];
        ref_mem[ins] = d;
        chk_mem({req, " contents"});
    endtask

    task automatic t_long_up();       run_op(5, 70, 8'hA1, 1'b0, "R3 long up");        endtask
    task automatic t_long_down();     run_op(100, 20, 8'hB2, 1'b0, "R4 long down");    endtask
    task automatic t_adjacent_up();   run_op(30, 40, 8'hC3, 1'b0, "R3 adjacent up");   endtask
    task automatic t_adjacent_down(); run_op(50, 44, 8'hD4, 1'b0, "R4 adjacent down"); endtask
    task automatic t_single_up();     run_op(50, 60, 8'hE5, 1'b0, "R3 single up");     endtask
    task automatic t_single_down();   run_op(61, 49, 8'hF6, 1'b0, "R4 single down");   endtask
    task automatic t_equal();         run_op(77, 77, 8'h99, 1'b0, "R5 equal");         endtask
    task automatic t_span_up();       run_op(0, 127, 8'h11, 1'b0, "R3 full span up");  endtask
    task automatic t_span_down();     run_op(127, 0, 8'h22, 1'b0, "R4 full span down"); endtask
    task automatic t_ins_col_end_up();   run_op(31, 64, 8'h44, 1'b0, "R3 insert at column end"); endtask
    task automatic t_ins_col_start_dn(); run_op(64, 31, 8'h55, 1'b0, "R4 insert at column start"); endtask

    task automatic t_busy();
        int extra = 0;
        run_op(16, 100, 8'h33, 1'b1, "R9 busy refused");
        for (int k = 0; k < 10; k++) begin
            if (done || !cmd_ready) extra++;
            @(negedge clk);
        end
        chk("R9 no extra command after busy", extra, 0);
        chk_mem("R9 contents after idle period");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_long_up();
        t_long_down();
        t_adjacent_up();
        t_adjacent_down();
        t_single_up();
        t_single_down();
        t_equal();
        t_span_up();
        t_span_down();
        t_ins_col_end_up();
        t_ins_col_start_dn();
        t_busy();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule